// File: doc/BRIEF.md
# Serial Configuration Loader

This block programs a configurable logic device through its one-bit serial configuration port. On a start pulse it pulses the device's program line, follows the device's init line through its clear cycle, then takes image bytes from a valid/ready stream. It shifts each byte out on a data line, most significant bit first, against a configuration clock that it generates itself. After the byte flagged as last, it keeps the data line high and keeps clocking until the device raises done. It finishes with a one-cycle completion pulse and a two-bit result code.

While it waits for the next byte, the loader watches for an error reported by the device. That error is init going active (low) while done is still low. It also bounds each wait on the device with a timeout counter. One half-period of the configuration clock lasts a parameterised number of system clocks, so the serial rate can sit well below the system clock rate.

Top module: `cfgload_serial`

## Requirements
- R1: After reset the loader is idle: `busy_o`, `prog_o`, `cclk_o`, `dout_o`, `s_ready_o` and `fin_o` are all 0. A `start_i` pulse seen while idle begins a load.
- R2: A load first drives `prog_o` high, with `cclk_o` low and `s_ready_o` low. It holds `prog_o` high until `init_n_i` is low. If `init_n_i` stays high for TIMEOUT_CYC cycles, the load ends with result 01.
- R3: Once `init_n_i` is low, `prog_o` drops and the loader waits for `init_n_i` to return high. If it stays low for TIMEOUT_CYC cycles, the load ends with result 01.
- R4: Each byte goes out as eight bits, bit 7 first and bit 0 last. The device captures each bit on a rising edge of `cclk_o`.
- R5: For each bit, `cclk_o` falls first. `dout_o` then changes one system clock later, and `cclk_o` rises with `dout_o` unchanged. Every high phase of `cclk_o` inside a byte lasts exactly HALF_CYC system clocks.
- R6: `s_ready_o` is high only between bytes. A new byte is accepted only after the rising edge of the previous byte's eighth bit, and exactly one byte is taken per handshake.
- R7: While waiting for a byte, if `done_i` is low and `init_n_i` is low, the loader accepts no further byte and ends at once with result 11.
- R8: After the last byte (marked by `s_last_i`), `dout_o` is held at 1 and `cclk_o` keeps toggling. When `done_i` is seen high, the load ends with result 00 and the clock stops.
- R9: If `done_i` stays low for TIMEOUT_CYC cycles after the last byte, the load ends with result 10.
- R10: A load ends with `fin_o` high for exactly one cycle. `status_o` holds the result from that cycle on, and `busy_o` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a load (ignored while busy) |
| s_valid_i | input | 1 | Image byte valid |
| s_data_i | input | 8 | Image byte |
| s_last_i | input | 1 | Marks the final byte of the image |
| s_ready_o | output | 1 | Loader takes a byte this cycle when valid |
| init_n_i | input | 1 | Device init line, low = active |
| done_i | input | 1 | Device done line, high = configured |
| prog_o | output | 1 | Program request to the device, high = asserted |
| cclk_o | output | 1 | Configuration clock |
| dout_o | output | 1 | Serial configuration data |
| busy_o | output | 1 | A load is in progress |
| fin_o | output | 1 | One-cycle pulse at the end of a load |
| status_o | output | 2 | Result: 00 ok, 01 init timeout, 10 done timeout, 11 CRC error |

## Verification
The bench plays the device. It pulls init low in answer to the program pulse, captures bits on clock rising edges, and raises done after a set number of trailing clocks. Against that model it checks byte order with asymmetric patterns; a loader that shifts LSB first or drops a bit would capture mirrored or shifted bytes. It measures the clock high time inside bytes and counts trailing edges, which a loader with an off-by-one half-period counter or one that keeps clocking after done would fail. It stalls each init phase and the done phase to get the two timeout codes. It raises a CRC error after the first byte and checks that the second byte is never taken, which a loader that checks only once per load would miss.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      RES_OK       = 2'b00,
      RES_INIT_TMO = 2'b01,
      RES_DONE_TMO = 2'b10,
      RES_CRC      = 2'b11
   } cfgld_res_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_PROG,
      S_WAKE,
      S_FETCH,
      S_SHIFT,
      S_TRAIL,
      S_FIN
   } cfgld_st_e;
endpackage

// File: rtl/cfgld_tmo.sv
module cfgld_tmo #(
   parameter int LIMIT = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic run_i,
   output logic exp_o
);
   localparam int TW = $clog2(LIMIT + 1);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("cfgld_tmo: LIMIT must be at least 1");
      end
   endgenerate

   logic [TW-1:0] cnt;

   assign exp_o = (cnt == TW'(LIMIT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt <= '0;
      else if (clr_i)            cnt <= '0;
      else if (run_i && !exp_o)  cnt <= cnt + 1'b1;
   end

   // R9: once expired the timer stays expired until cleared
   p_tmo_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (exp_o && !clr_i) |=> exp_o);
endmodule

// File: rtl/cfgld_halfcnt.sv
module cfgld_halfcnt #(
   parameter int HALF = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic en_i,
   output logic tick_o,
   output logic first_o
);
   localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

   generate
      if (HALF < 2) begin : g_bad_half
         $error("cfgld_halfcnt: HALF must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   assign tick_o  = en_i && (cnt == CW'(HALF - 1));
   assign first_o = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (clr_i)   cnt <= '0;
      else if (en_i)    cnt <= tick_o ? '0 : cnt + 1'b1;
   end

   // R5: a phase end restarts the count of the next phase
   p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> first_o);
endmodule

// File: rtl/cfgld_shreg.sv
module cfgld_shreg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] data_i,
   input  logic         shift_i,
   output logic         msb_o,
   output logic         last_o
);
   localparam int IW = (W > 1) ? $clog2(W) : 1;

   generate
      if (W < 2) begin : g_bad_w
         $error("cfgld_shreg: W must be at least 2");
      end
   endgenerate

   logic [W-1:0]  sh;
   logic [IW-1:0] idx;

   assign msb_o  = sh[W-1];
   assign last_o = (idx == IW'(W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh  <= '0;
         idx <= '0;
      end else if (load_i) begin
         sh  <= data_i;
         idx <= '0;
      end else if (shift_i) begin
         sh  <= {sh[W-2:0], 1'b0};
         idx <= last_o ? '0 : idx + 1'b1;
      end
   end

   // R4: a shift never coincides with a load
   p_no_clash_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(load_i && shift_i));
endmodule

// File: rtl/cfgload_serial.sv
module cfgload_serial
   import cfgld_pkg::*;
#(
   parameter int HALF_CYC    = 4,
   parameter int TIMEOUT_CYC = 1_000_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              s_valid_i,
   input  logic [BYTE_W-1:0] s_data_i,
   input  logic              s_last_i,
   output logic              s_ready_o,
   input  logic              init_n_i,
   input  logic              done_i,
   output logic              prog_o,
   output logic              cclk_o,
   output logic              dout_o,
   output logic              busy_o,
   output logic              fin_o,
   output logic [1:0]        status_o
);
   cfgld_st_e  st, st_nxt;
   cfgld_res_e res_q, res_nxt;
   logic       cclk_q, dout_q, last_q;
   logic       tmo_exp, tick, first;
   logic       msb, last_bit;
   logic       crc_err, accept, shift_now, leave;

   assign crc_err   = (st == S_FETCH) && !done_i && !init_n_i;
   assign s_ready_o = (st == S_FETCH) && !crc_err;
   assign accept    = s_ready_o && s_valid_i;
   assign shift_now = (st == S_SHIFT) && tick && cclk_q;
   assign leave     = (st_nxt != st);

   always_comb begin
      st_nxt  = st;
      res_nxt = res_q;
      unique case (st)
         S_IDLE:  if (start_i) st_nxt = S_PROG;
         S_PROG: begin
            if (!init_n_i)    st_nxt = S_WAKE;
            else if (tmo_exp) begin st_nxt = S_FIN; res_nxt = RES_INIT_TMO; end
         end
         S_WAKE: begin
            if (init_n_i)     st_nxt = S_FETCH;
            else if (tmo_exp) begin st_nxt = S_FIN; res_nxt = RES_INIT_TMO; end
         end
         S_FETCH: begin
            if (crc_err)      begin st_nxt = S_FIN; res_nxt = RES_CRC; end
            else if (accept)  st_nxt = S_SHIFT;
         end
         S_SHIFT: if (shift_now && last_bit) st_nxt = last_q ? S_TRAIL : S_FETCH;
         S_TRAIL: begin
            if (done_i)       begin st_nxt = S_FIN; res_nxt = RES_OK; end
            else if (tmo_exp) begin st_nxt = S_FIN; res_nxt = RES_DONE_TMO; end
         end
         S_FIN:   st_nxt = S_IDLE;
         default: st_nxt = S_IDLE;
      endcase
   end

   cfgld_tmo #(.LIMIT(TIMEOUT_CYC)) u_tmo (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (leave),
      .run_i ((st == S_PROG) || (st == S_WAKE) || (st == S_TRAIL)),
      .exp_o (tmo_exp)
   );

   cfgld_halfcnt #(.HALF(HALF_CYC)) u_half (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (leave),
      .en_i    ((st == S_SHIFT) || (st == S_TRAIL)),
      .tick_o  (tick),
      .first_o (first)
   );

   cfgld_shreg #(.W(BYTE_W)) u_sh (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (accept),
      .data_i  (s_data_i),
      .shift_i (shift_now),
      .msb_o   (msb),
      .last_o  (last_bit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         res_q  <= RES_OK;
         cclk_q <= 1'b0;
         dout_q <= 1'b0;
         last_q <= 1'b0;
      end else begin
         st    <= st_nxt;
         res_q <= res_nxt;
         if (accept) last_q <= s_last_i;
         unique case (st)
            S_FETCH: if (accept) cclk_q <= 1'b0;
            S_SHIFT: begin
               if (!cclk_q && first) dout_q <= msb;
               if (tick) begin
                  if (!(cclk_q && last_bit)) cclk_q <= !cclk_q;
                  else if (last_q)           cclk_q <= 1'b0;
               end
            end
            S_TRAIL: begin
               dout_q <= 1'b1;
               if (tick && !done_i) cclk_q <= !cclk_q;
            end
            S_IDLE, S_FIN: begin
               cclk_q <= 1'b0;
               dout_q <= 1'b0;
            end
            default: ;
         endcase
      end
   end

   assign prog_o   = (st == S_PROG);
   assign cclk_o   = cclk_q;
   assign dout_o   = dout_q;
   assign busy_o   = (st != S_IDLE);
   assign fin_o    = (st == S_FIN);
   assign status_o = res_q;

   // R2: during the program pulse nothing else moves
   p_prog_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      prog_o |-> (!cclk_o && !s_ready_o));
   // R5: data is settled before each rising clock edge
   p_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cclk_o) |-> $stable(dout_o));
   // R6: a handshake is followed by shifting, not another fetch
   p_one_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (s_ready_o && s_valid_i) |=> !s_ready_o);
   // R7: an error seen while fetching ends the load with code 11
   p_crc_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == S_FETCH) && !done_i && !init_n_i) |=> (fin_o && status_o == RES_CRC));
   // R8: trailing data line stays high
   p_trail_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == S_TRAIL) && ($past(st) == S_TRAIL)) |-> dout_o);
   // R10: completion is a single-cycle pulse followed by idle
   p_fin_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fin_o |=> (!fin_o && !busy_o));
endmodule

// File: tb/tb_cfgload_serial.sv
module tb_cfgload_serial;
   localparam int HALF = 3;
   localparam int TMO  = 400;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       s_valid = 1'b0;
   logic [7:0] s_data = 8'h00;
   logic       s_last = 1'b0;
   logic       s_ready, prog, cclk, dout, busy, fin;
   logic [1:0] status;
   logic       init_reg = 1'b1, crc_pull = 1'b0, done_reg = 1'b0;
   wire        init_n = init_reg && !crc_pull;

   int checks = 0, errors = 0, cycles = 0;

   cfgload_serial #(.HALF_CYC(HALF), .TIMEOUT_CYC(TMO)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start),
      .s_valid_i(s_valid), .s_data_i(s_data), .s_last_i(s_last), .s_ready_o(s_ready),
      .init_n_i(init_n), .done_i(done_reg),
      .prog_o(prog), .cclk_o(cclk), .dout_o(dout),
      .busy_o(busy), .fin_o(fin), .status_o(status)
   );

   always #5 clk = ~clk;

   // device model and stream feeder state
   logic [7:0] mem [0:7];
   logic [7:0] rx  [0:7];
   int  feed_n = 0, feed_i = 0, acc_cnt = 0;
   logic hs = 1'b0;
   bit  m_lo = 1, m_rel = 1, m_done = 1;
   int  m_crc_after = 0;
   int  rx_bits = 0, trail_rises = 0, trail_bad = 0;
   int  hi_run = 0, hi_bad = 0, hi_seen = 0, fin_cnt = 0;
   logic [7:0] rx_sh = 8'h00;
   logic cclk_prev = 1'b0;
   logic [1:0] fin_status = 2'b00;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   always @(posedge clk) hs <= s_valid && s_ready;

   always @(negedge clk) begin
      cycles++;
      if (hs) begin feed_i++; acc_cnt++; end
      if (feed_i < feed_n) begin
         s_valid = 1'b1; s_data = mem[feed_i]; s_last = (feed_i == feed_n - 1);
      end else begin
         s_valid = 1'b0; s_last = 1'b0;
      end
      if (prog && m_lo) init_reg = 1'b0;
      else if (!prog && !init_reg && m_rel) init_reg = 1'b1;
      if (cclk && !cclk_prev) begin
         if (rx_bits < 8 * feed_n) begin
            rx_sh = {rx_sh[6:0], dout};
            rx_bits++;
            if (rx_bits % 8 == 0) rx[rx_bits / 8 - 1] = rx_sh;
         end else begin
            trail_rises++;
            if (!dout) trail_bad++;
         end
      end
      if (cclk) hi_run++;
      if (!cclk && cclk_prev) begin
         if (rx_bits % 8 != 0) begin
            hi_seen++;
            if (hi_run != HALF) hi_bad++;
         end
         hi_run = 0;
      end
      cclk_prev = cclk;
      if (m_crc_after > 0 && rx_bits >= 8 * m_crc_after) crc_pull = 1'b1;
      if (m_done && trail_rises >= 3) done_reg = 1'b1;
      if (fin) begin fin_cnt++; fin_status = status; end
   end

   task automatic arm(input int n, input bit lo, input bit rel, input bit dn, input int crc_after);
      @(negedge clk);
      feed_n = n; feed_i = 0; acc_cnt = 0;
      m_lo = lo; m_rel = rel; m_done = dn; m_crc_after = crc_after;
      rx_bits = 0; trail_rises = 0; trail_bad = 0; hi_bad = 0; hi_seen = 0;
      init_reg = 1'b1; crc_pull = 1'b0; done_reg = 1'b0;
   endtask

   task automatic run(output int dur);
      int base;
      base = fin_cnt;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      dur = 1;
      while (fin_cnt == base && dur < 20000) begin @(negedge clk); dur++; end
      @(negedge clk);
      chk(!busy, "R10 idle after fin", busy, 0);
   endtask

   task automatic t_reset;
      chk({busy, prog, cclk, dout, s_ready, fin} == 6'b0, "R1 reset outputs",
          {busy, prog, cclk, dout, s_ready, fin}, 0);
   endtask

   task automatic t_load(input int n);
      int dur;
      arm(n, 1, 1, 1, 0);
      run(dur);
      chk(fin_status == 2'b00, "R8 success code", fin_status, 0);
      chk(acc_cnt == n, "R6 bytes accepted", acc_cnt, n);
      for (int i = 0; i < n; i++)
         chk(rx[i] == mem[i], "R4 byte order", rx[i], mem[i]);
      chk(hi_seen > 0 && hi_bad == 0, "R5 high phase width", hi_bad, 0);
      chk(trail_rises == 3 && trail_bad == 0, "R8 trailing clocks", trail_rises, 3);
   endtask

   task automatic t_init_stuck;
      int dur;
      arm(1, 0, 1, 1, 0);
      run(dur);
      chk(fin_status == 2'b01, "R2 init timeout code", fin_status, 1);
      chk(dur >= TMO && dur <= TMO + 8, "R2 timeout length", dur, TMO);
      chk(acc_cnt == 0, "R2 no byte taken", acc_cnt, 0);
   endtask

   task automatic t_init_hold;
      int dur;
      arm(1, 1, 0, 1, 0);
      run(dur);
      chk(fin_status == 2'b01, "R3 init release timeout code", fin_status, 1);
      chk(dur >= TMO && dur <= TMO + 10, "R3 timeout length", dur, TMO);
   endtask

   task automatic t_done_tmo;
      int dur;
      arm(2, 1, 1, 0, 0);
      run(dur);
      chk(fin_status == 2'b10, "R9 done timeout code", fin_status, 2);
      chk(trail_rises > 3 && trail_bad == 0, "R9 clocking while waiting", trail_rises, 4);
   endtask

   task automatic t_crc;
      int dur;
      arm(3, 1, 1, 1, 1);
      run(dur);
      chk(fin_status == 2'b11, "R7 crc code", fin_status, 3);
      chk(acc_cnt == 1, "R7 no byte after error", acc_cnt, 1);
      chk(rx_bits == 8, "R7 bits sent", rx_bits, 8);
   endtask

   initial begin
      mem[0] = 8'hA5; mem[1] = 8'h3C; mem[2] = 8'h81; mem[3] = 8'h0E;
      mem[4] = 8'hF0; mem[5] = 8'h01; mem[6] = 8'h7F; mem[7] = 8'hC2;
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_load(4);
      mem[0] = 8'h80;
      t_load(1);
      mem[0] = 8'h12; mem[1] = 8'h34; mem[2] = 8'h56; mem[3] = 8'h78;
      t_load(8);
      t_init_stuck;
      t_init_hold;
      t_done_tmo;
      t_crc;
      t_load(2);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      wait (cycles > 100000);
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule